// File: doc/BRIEF.md
# Peripheral Soft-Reset Sequencer

This block is a hardware sequencer that brings a peripheral out of reset, or puts it through a complete reset cycle. It works only through that peripheral's 32-bit control register. It reaches the register through a single-register access master port and steps through a fixed list of read-modify-write and polling steps on two control bits: the soft-reset flag in bit 31 and the clock-gate flag in bit 30.

A one-cycle `start` pulse begins a run. The `full_reset` input, sampled with `start`, picks one of two sequences:

- **Enable-only:** release the reset flag, wait for it to read 0, remove the clock gate, and wait for the gate flag to read 0.
- **Full reset:** does the same, but between removing the gate and the final wait it inserts a reset pulse. It sets the reset flag and waits for the gate flag to read 1. It then clears the reset flag, waits for it to read 0, and clears the gate flag again.

Every poll is bounded. A poll that runs out of reads fails the attempt, and the whole sequence is run again from its first step, up to a fixed number of attempts. The run ends with a one-cycle `done` or `err`. The number of attempts used and a code for the step that last timed out remain readable until the next start.

The control states are:

- `ST_IDLE`
- `ST_READ`, which covers both the read half of a read-modify-write and a poll read
- `ST_WRITE`
- `ST_DONE`
- `ST_FAIL`

The transitions are:

- **launch:** `ST_IDLE` to `ST_READ` on `start`.
- **patch:** `ST_READ` to `ST_WRITE` when a read-modify-write read is acknowledged.
- **advance:** `ST_WRITE` to `ST_READ` when the write is acknowledged.
- **repoll:** `ST_READ` to `ST_READ` when a poll read misses and reads remain.
- **step-on:** `ST_READ` to `ST_READ` when a poll matches and is not the last step.
- **retry:** `ST_READ` to `ST_READ` at the first step when a poll times out and attempts remain.
- **finish:** `ST_READ` to `ST_DONE` when the last poll matches.
- **give-up:** `ST_READ` to `ST_FAIL` when a poll times out on the last permitted attempt.
- **settle:** `ST_DONE` or `ST_FAIL` to `ST_IDLE` after one cycle.

Top module: `rstseq_top`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `err` and `bus_req` are 0, and `attempts` and `fail_phase` are 0.
- R2: Each access holds `bus_req`, `bus_we` and `bus_wdata` steady until the cycle in which `bus_ack` is 1. Only one access is outstanding at a time, and `bus_req` is 0 whenever the block is idle.
- R3: Every write is a read-modify-write. It differs from the value just read only in the targeted bit (bit 31 is the soft-reset flag, bit 30 is the clock-gate flag), so bits 29..0 are written back unchanged.
- R4: Enable-only mode (`full_reset`=0) issues exactly two writes per successful attempt. The first has {bit31,bit30} = 01 (reset released) and the second has 00 (gate removed). Each write is followed by a poll for the reset flag reading 0 and the gate flag reading 0 respectively.
- R5: Full-reset mode (`full_reset`=1), starting from a register with both flags set, issues five writes with {bit31,bit30} = 01, 00, 10, 01, 00. After the third write it polls for the gate flag reading 1. After the fourth write it polls for the reset flag reading 0.
- R6: A poll gives up after exactly POLL_LIMIT reads that miss the expected value.
- R7: A timed-out poll restarts the sequence at its first step. If a later attempt succeeds, `done` pulses and `attempts` equals the number of that attempt.
- R8: After RETRY_LIMIT failed attempts, `err` pulses and `attempts` equals RETRY_LIMIT.
- R9: `fail_phase` gives the step that last timed out: 1 for the first release wait, 2 for the wait for the gate flag to set, 3 for the release wait after the reset pulse, and 4 for the final un-gate wait. It is cleared to 0 and `attempts` is set to 1 at every start.
- R10: `done` and `err` are single-cycle pulses that never coincide. `busy` is 1 from the cycle after `start` through the pulse cycle, and 0 in the cycle that follows.
- R11: A `start` that arrives while `busy` is 1 is ignored, and so is its `full_reset` value.
- R12: `attempts` and `fail_phase` keep their values while idle until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| full_reset | input | 1 | 1 selects a full reset, 0 selects enable-only |
| bus_req | output | 1 | Access request, held until acknowledged |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_wdata | output | 32 | Write data for the control register |
| bus_rdata | input | 32 | Read data, valid when `bus_ack` is 1 on a read |
| bus_ack | input | 1 | Access completes in this cycle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: the sequence succeeded |
| err | output | 1 | One-cycle pulse: all attempts failed |
| fail_phase | output | 3 | Code of the step that last timed out |
| attempts | output | clog2(RETRY_LIMIT+1) | Attempts used in the latest run |

## Verification
A wrong step pointer shows up at the bus within one access. The next write carries the wrong flag pattern, or a poll waits on the wrong bit and stalls for POLL_LIMIT reads. A poll counter that is off by one changes the number of reads made before a retry by exactly one. That difference appears in the read count the moment the attempt is abandoned. A faulty attempt counter or phase register is visible on `attempts` and `fail_phase` at the `done` or `err` pulse, and stays visible while the block is idle.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_DONE,
        ST_FAIL
    } state_t;

    typedef enum logic [3:0] {
        SP_CLR_RST_A,
        SP_WAIT_RUN_A,
        SP_CLR_GATE_A,
        SP_SET_RST,
        SP_WAIT_GATE_ON,
        SP_CLR_RST_B,
        SP_WAIT_RUN_B,
        SP_CLR_GATE_B,
        SP_WAIT_UNGATE
    } step_t;

    typedef enum logic [2:0] {
        PH_NONE     = 3'd0,
        PH_ENABLE   = 3'd1,
        PH_RESET    = 3'd2,
        PH_REENABLE = 3'd3,
        PH_UNGATE   = 3'd4
    } phase_t;

    // Step reads and compares rather than patching and writing.
    function automatic logic step_polls(step_t s);
        return (s == SP_WAIT_RUN_A) || (s == SP_WAIT_GATE_ON) ||
               (s == SP_WAIT_RUN_B) || (s == SP_WAIT_UNGATE);
    endfunction

    // Step targets the soft-reset flag (else the clock-gate flag).
    function automatic logic step_on_rst(step_t s);
        return (s == SP_CLR_RST_A) || (s == SP_WAIT_RUN_A) ||
               (s == SP_SET_RST)   || (s == SP_CLR_RST_B)  ||
               (s == SP_WAIT_RUN_B);
    endfunction

    // Value written, or value awaited, for the targeted flag.
    function automatic logic step_level(step_t s);
        return (s == SP_SET_RST) || (s == SP_WAIT_GATE_ON);
    endfunction

    function automatic phase_t step_phase(step_t s);
        case (s)
            SP_WAIT_RUN_A:   return PH_ENABLE;
            SP_WAIT_GATE_ON: return PH_RESET;
            SP_WAIT_RUN_B:   return PH_REENABLE;
            SP_WAIT_UNGATE:  return PH_UNGATE;
            default:         return PH_NONE;
        endcase
    endfunction

    function automatic step_t step_after(step_t s, logic full);
        case (s)
            SP_CLR_RST_A:    return SP_WAIT_RUN_A;
            SP_WAIT_RUN_A:   return SP_CLR_GATE_A;
            SP_CLR_GATE_A:   return full ? SP_SET_RST : SP_WAIT_UNGATE;
            SP_SET_RST:      return SP_WAIT_GATE_ON;
            SP_WAIT_GATE_ON: return SP_CLR_RST_B;
            SP_CLR_RST_B:    return SP_WAIT_RUN_B;
            SP_WAIT_RUN_B:   return SP_CLR_GATE_B;
            SP_CLR_GATE_B:   return SP_WAIT_UNGATE;
            default:         return SP_WAIT_UNGATE;
        endcase
    endfunction

endpackage

// File: rtl/rstseq_poll_timer.sv
module rstseq_poll_timer #(
    parameter int unsigned LIMIT = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic at_last
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The current miss is the LIMIT-th one.
    assign at_last = (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/rstseq_attempt_ctr.sv
module rstseq_attempt_ctr #(
    parameter int unsigned LIMIT = 10,
    localparam int unsigned AW = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_one,
    input  logic          inc,
    output logic [AW-1:0] count,
    output logic          last
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load_one) begin
            count <= AW'(1);
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

    assign last = (count == AW'(LIMIT));

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int unsigned POLL_LIMIT  = 1000000,
    parameter int unsigned RETRY_LIMIT = 10,
    parameter int unsigned DATA_W      = 32,
    localparam int unsigned AW = $clog2(RETRY_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              full_reset,
    output logic              bus_req,
    output logic              bus_we,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [2:0]        fail_phase,
    output logic [AW-1:0]     attempts
);
    localparam int unsigned RST_BIT  = DATA_W - 1;
    localparam int unsigned GATE_BIT = DATA_W - 2;

    state_t            state_q, state_d;
    step_t             step_q, step_d;
    phase_t            phase_q, phase_d;
    logic              full_q, full_d;
    logic [DATA_W-1:0] wdata_q, wdata_d;

    logic              t_clr, t_tick, t_last;
    logic              a_load, a_inc, a_last;
    logic              rd_flag, poll_hit;
    logic [DATA_W-1:0] patched;

    rstseq_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (t_clr),
        .tick    (t_tick),
        .at_last (t_last)
    );

    rstseq_attempt_ctr #(.LIMIT(RETRY_LIMIT)) u_tries (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_one (a_load),
        .inc      (a_inc),
        .count    (attempts),
        .last     (a_last)
    );

    // Data path: the flag under test and the patched write value.
    always_comb begin
        rd_flag  = step_on_rst(step_q) ? bus_rdata[RST_BIT] : bus_rdata[GATE_BIT];
        poll_hit = (rd_flag == step_level(step_q));
        patched  = bus_rdata;
        if (step_on_rst(step_q)) begin
            patched[RST_BIT] = step_level(step_q);
        end else begin
            patched[GATE_BIT] = step_level(step_q);
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        phase_d = phase_q;
        full_d  = full_q;
        wdata_d = wdata_q;
        t_clr   = 1'b0;
        t_tick  = 1'b0;
        a_load  = 1'b0;
        a_inc   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin                       // launch
                    state_d = ST_READ;
                    step_d  = SP_CLR_RST_A;
                    full_d  = full_reset;
                    phase_d = PH_NONE;
                    t_clr   = 1'b1;
                    a_load  = 1'b1;
                end
            end
            ST_READ: begin
                if (bus_ack) begin
                    if (!step_polls(step_q)) begin     // patch
                        wdata_d = patched;
                        state_d = ST_WRITE;
                    end else if (poll_hit) begin
                        t_clr = 1'b1;
                        if (step_q == SP_WAIT_UNGATE) begin
                            state_d = ST_DONE;         // finish
                        end else begin
                            step_d = step_after(step_q, full_q);  // step-on
                        end
                    end else if (t_last) begin
                        t_clr   = 1'b1;
                        phase_d = step_phase(step_q);
                        if (a_last) begin
                            state_d = ST_FAIL;         // give-up
                        end else begin
                            a_inc  = 1'b1;             // retry
                            step_d = SP_CLR_RST_A;
                        end
                    end else begin
                        t_tick = 1'b1;                 // repoll
                    end
                end
            end
            ST_WRITE: begin
                if (bus_ack) begin                     // advance
                    step_d  = step_after(step_q, full_q);
                    state_d = ST_READ;
                end
            end
            ST_DONE, ST_FAIL: begin
                state_d = ST_IDLE;                     // settle
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= SP_CLR_RST_A;
            phase_q <= PH_NONE;
            full_q  <= 1'b0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            phase_q <= phase_d;
            full_q  <= full_d;
            wdata_q <= wdata_d;
        end
    end

    // Outputs.
    always_comb begin
        bus_req    = (state_q == ST_READ) || (state_q == ST_WRITE);
        bus_we     = (state_q == ST_WRITE);
        bus_wdata  = wdata_q;
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_DONE);
        err        = (state_q == ST_FAIL);
        fail_phase = phase_q;
    end

endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
    parameter int unsigned RETRY_LIMIT = 10,
    parameter int unsigned DATA_W      = 32,
    localparam int unsigned AW = $clog2(RETRY_LIMIT + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              bus_req,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ack,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [2:0]        fail_phase,
    input logic [AW-1:0]     attempts
);
    a_r2_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_wdata));

    a_r2_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    a_r10_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err && !busy);

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    a_r10_busy_until_end: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done && !err |=> busy);

    a_r8_err_exhausted: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (attempts == AW'(RETRY_LIMIT)) && (fail_phase != 3'd0));

    a_r7_attempt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        attempts <= AW'(RETRY_LIMIT));

    a_r9_fresh_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (attempts == AW'(1)) && (fail_phase == 3'd0));

    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(attempts) && $stable(fail_phase));

endmodule

bind rstseq_top rstseq_chk #(.RETRY_LIMIT(RETRY_LIMIT), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_ack    (bus_ack),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .fail_phase (fail_phase),
    .attempts   (attempts)
);

// File: tb/sim_rstseq_top.sv
`timescale 1ns/1ps
module sim_rstseq_top;
    localparam int unsigned PL = 4;
    localparam int unsigned RL = 3;
    localparam int unsigned AW = $clog2(RL + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          full_reset = 1'b0;
    logic          bus_req, bus_we, bus_ack;
    logic [31:0]   bus_wdata, bus_rdata;
    logic          busy, done, err;
    logic [2:0]    fail_phase;
    logic [AW-1:0] attempts;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rstseq_top #(.POLL_LIMIT(PL), .RETRY_LIMIT(RL)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .full_reset(full_reset),
        .bus_req(bus_req), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .busy(busy), .done(done),
        .err(err), .fail_phase(fail_phase), .attempts(attempts)
    );

    // Peripheral register model.
    logic [31:0] ctrl;
    logic        ack_r = 1'b0;
    logic [31:0] rdata_r = '0;
    logic [31:0] last_rd;
    int          stuck_reads;
    bit          gate_no_set, gate_forced, hold_armed, hold_active;
    int          n_reads, n_writes, rmw_viol, proto_viol;
    logic [1:0]  wlog [16];
    int          done_cnt, err_cnt, pulse_viol;
    logic        prev_done = 1'b0, prev_err = 1'b0;
    logic        pend = 1'b0, pend_we = 1'b0;
    logic [31:0] pend_wd = '0;

    assign bus_ack   = ack_r;
    assign bus_rdata = rdata_r;

    always @(posedge clk) begin
        logic [31:0] nv;
        if (!rst_n) begin
            ack_r <= 1'b0;
            pend  <= 1'b0;
        end else begin
            if (pend && (!bus_req || bus_we != pend_we || (bus_we && bus_wdata != pend_wd)))
                proto_viol++;
            pend    <= bus_req && !ack_r;
            pend_we <= bus_we;
            pend_wd <= bus_wdata;
            if (bus_req && !ack_r) begin
                ack_r <= 1'b1;
                if (bus_we) begin
                    nv = bus_wdata;
                    if (((bus_wdata ^ last_rd) & 32'h3FFF_FFFF) != 0 ||
                        $countones(bus_wdata ^ last_rd) > 1)
                        rmw_viol++;
                    if (hold_active && !bus_wdata[31]) begin
                        nv[31] = 1'b1;
                        hold_active = 1'b0;
                    end
                    if (bus_wdata[31] && hold_armed) begin
                        hold_active = 1'b1;
                        hold_armed  = 1'b0;
                    end
                    if (bus_wdata[31] && !ctrl[31] && !gate_no_set) nv[30] = 1'b1;
                    ctrl = nv;
                    if (n_writes < 16) wlog[n_writes] = bus_wdata[31:30];
                    n_writes++;
                end else begin
                    nv = ctrl;
                    if (stuck_reads > 0) begin
                        nv[31] = 1'b1;
                        stuck_reads--;
                    end
                    if (gate_forced) nv[30] = 1'b1;
                    rdata_r <= nv;
                    last_rd = nv;
                    n_reads++;
                end
            end else begin
                ack_r <= 1'b0;
            end
            if (done) done_cnt++;
            if (err) err_cnt++;
            if ((done && prev_done) || (err && prev_err) || (done && err)) pulse_viol++;
            prev_done <= done;
            prev_err  <= err;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg(input int stuck, input bit no_set, input bit forced, input bit hold);
        @(negedge clk);
        ctrl        = 32'hC000_5A5A;
        last_rd     = ctrl;
        stuck_reads = stuck;
        gate_no_set = no_set;
        gate_forced = forced;
        hold_armed  = hold;
        hold_active = 1'b0;
        n_reads     = 0;
        n_writes    = 0;
        rmw_viol    = 0;
        done_cnt    = 0;
        err_cnt     = 0;
        for (int i = 0; i < 16; i++) wlog[i] = 2'b11;
    endtask

    // Launch a run; optionally poke start while busy.
    task automatic go(input bit full, input bit poke, output bit saw_done, output bit saw_err);
        bit fin = 1'b0;
        saw_done = 1'b0;
        saw_err  = 1'b0;
        start = 1'b1;
        full_reset = full;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R10 busy after start", busy, 1);
        chk("R9 attempts at start", attempts, 1);
        chk("R9 phase cleared at start", fail_phase, 0);
        for (int i = 0; i < 3000; i++) begin
            if (done || err) begin
                fin = 1'b1;
                saw_done = done;
                saw_err  = err;
                break;
            end
            if (poke && i == 5) begin
                start = 1'b1;
                full_reset = ~full;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk("R10 run finished", fin, 1);
        @(negedge clk);
        chk("R10 busy low after pulse", busy, 0);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 err", err, 0);
        chk("R1 bus_req", bus_req, 0);
        chk("R1 attempts", attempts, 0);
        chk("R1 fail_phase", fail_phase, 0);
    endtask

    task automatic t_enable_only();
        bit d, e;
        cfg(0, 0, 0, 0);
        go(1'b0, 1'b0, d, e);
        chk("R4 done", d, 1);
        chk("R4 writes", n_writes, 2);
        chk("R4 write 1 flags", wlog[0], 2'b01);
        chk("R4 write 2 flags", wlog[1], 2'b00);
        chk("R7 attempts", attempts, 1);
        chk("R3 rmw", rmw_viol, 0);
        chk("R3 low bits", ctrl[29:0], 30'h0000_5A5A);
    endtask

    task automatic t_full();
        bit d, e;
        cfg(0, 0, 0, 0);
        go(1'b1, 1'b0, d, e);
        chk("R5 done", d, 1);
        chk("R5 writes", n_writes, 5);
        chk("R5 w1", wlog[0], 2'b01);
        chk("R5 w2", wlog[1], 2'b00);
        chk("R5 w3", wlog[2], 2'b10);
        chk("R5 w4", wlog[3], 2'b01);
        chk("R5 w5", wlog[4], 2'b00);
        chk("R3 rmw full", rmw_viol, 0);
        chk("R3 low bits full", ctrl[29:0], 30'h0000_5A5A);
    endtask

    task automatic t_retry_enable();
        bit d, e;
        cfg(5, 0, 0, 0);
        go(1'b0, 1'b0, d, e);
        chk("R7 done after retry", d, 1);
        chk("R7 attempts", attempts, 2);
        chk("R9 phase enable", fail_phase, 1);
        chk("R6 reads", n_reads, 9);
        chk("R7 writes", n_writes, 3);
        chk("R7 restart at first step", wlog[1], 2'b01);
    endtask

    task automatic t_retry_reenable();
        bit d, e;
        cfg(0, 0, 0, 1);
        go(1'b1, 1'b0, d, e);
        chk("R7 done reenable", d, 1);
        chk("R7 attempts reenable", attempts, 2);
        chk("R9 phase reenable", fail_phase, 3);
        chk("R7 writes reenable", n_writes, 9);
        chk("R7 restart flags", wlog[4], 2'b01);
    endtask

    task automatic t_err_enable();
        bit d, e;
        cfg(1000, 0, 0, 0);
        go(1'b0, 1'b0, d, e);
        chk("R8 err", e, 1);
        chk("R8 no done", d, 0);
        chk("R8 attempts", attempts, RL);
        chk("R9 phase enable", fail_phase, 1);
        chk("R6 reads", n_reads, 15);
        chk("R7 writes", n_writes, 3);
        repeat (6) @(negedge clk);
        chk("R12 attempts held", attempts, RL);
        chk("R12 phase held", fail_phase, 1);
    endtask

    task automatic t_err_reset();
        bit d, e;
        cfg(0, 1, 0, 0);
        go(1'b1, 1'b0, d, e);
        chk("R8 err reset", e, 1);
        chk("R9 phase reset", fail_phase, 2);
        chk("R6 reads reset", n_reads, 24);
    endtask

    task automatic t_err_ungate();
        bit d, e;
        cfg(0, 0, 1, 0);
        go(1'b0, 1'b0, d, e);
        chk("R8 err ungate", e, 1);
        chk("R9 phase ungate", fail_phase, 4);
        chk("R6 reads ungate", n_reads, 21);
    endtask

    task automatic t_busy_start();
        bit d, e;
        cfg(0, 0, 0, 0);
        go(1'b1, 1'b1, d, e);
        chk("R11 done", d, 1);
        chk("R11 mode unchanged", n_writes, 5);
        repeat (10) @(negedge clk);
        chk("R11 no second run", busy, 0);
        chk("R11 single done", done_cnt, 1);
        chk("R10 pulse shape", pulse_viol, 0);
        chk("R2 handshake", proto_viol, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        pulse_viol = 0;
        proto_viol = 0;
        cfg(0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_only();
        t_full();
        t_retry_enable();
        t_retry_reenable();
        t_err_enable();
        t_err_reset();
        t_err_ungate();
        t_busy_start();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule